// File: doc/BRIEF.md
# Grant-Share Priority Generator

This block computes the arbitration priority of one requester on a five-port memory arbiter. It looks at recent bus activity. Each time the arbiter grants any port, and each time the bus has sat idle for a run of cycles, one bit goes into a 63-deep history. The bit records whether this channel took that slot. When the channel is not asking for the bus, the bit is a programmable fill value instead.

The history is cut down to the newest n entries, and the ones in that window are counted. The count is clamped to fifteen and used as an index into a sixteen-entry table of 4-bit priorities. The table is programmable, and a congestion input switches between a main table and an alternate one. The chosen entry is registered and drives the priority output.

The fill value sets the priority that an inactive channel comes back with. A fill of 1 makes the channel look as if it has been busy, so it returns at the low end of its table. A fill of 0 makes it return at the high end. The arbiter that consumes the priority is not part of this block.

Top module: `grant_share_prio`

## Requirements
- R1: A synchronous active-high reset clears the history, the idle-run counter and the priority output to zero.
- R2: The history shifts only in a cycle where some bit of `gnt` is set, or where an idle pulse occurs. In every other cycle it holds its value, even while requests are pending.
- R3: An idle pulse fires in the fourth consecutive cycle with `req` all zero. The counter then restarts, so an unbroken idle stretch gives one pulse every four cycles. Any request cycle restarts the count.
- R4: When the own channel (`req[self_idx]`) is requesting, the bit shifted in is `gnt[self_idx]`. If `self_idx` is 5 or higher, the channel is treated as never requesting.
- R5: When the own channel is not requesting, the bit shifted in is `fill_bit`.
- R6: Only the `win_len` newest history bits are counted, where bit 0 is the newest. A `win_len` of 0 gives a count of 0, and 63 counts the whole history.
- R7: The count of ones in the window is clamped to 15 and never wraps.
- R8: Entry k of the table occupies bits [4k+3:4k]. `use_alt`=1 selects `tbl_alt` and `use_alt`=0 selects `tbl_main`.
- R9: `prio` is registered. It shows the table entry for the history and controls as they stood before the last clock edge, which is one cycle after a shift or a control change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 5 | Request line of each port |
| gnt | input | 5 | Grant issued to each port this cycle |
| self_idx | input | 3 | Index of the port this instance serves |
| fill_bit | input | 1 | History bit recorded while the own port is not requesting |
| win_len | input | 6 | Number of newest history bits counted (0..63) |
| tbl_main | input | 64 | Main priority table, 16 entries of 4 bits |
| tbl_alt | input | 64 | Alternate priority table, same layout |
| use_alt | input | 1 | Selects the alternate table |
| prio | output | 4 | Registered channel priority |

## Verification
On every cycle the assertions check the following:
- the history holds when there is neither a grant nor an idle pulse;
- the newest history bit matches the own grant or the fill value, depending on whether the own port was requesting;
- idle pulses appear only after request-free cycles;
- a zero window yields a zero count.

Some behaviour can only be shown by the bench scenarios:
- the exact four-cycle spacing of idle pulses and its restart after a request;
- the window trimming away older history;
- saturation at fifteen;
- table entry placement and selection;
- the one-cycle output latency.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
    localparam int unsigned GSP_PORTS    = 5;
    localparam int unsigned GSP_HIST     = 63;
    localparam int unsigned GSP_IDLE_RUN = 4;
    localparam int unsigned GSP_PRIO_W   = 4;
endpackage

// File: rtl/gsp_idle_gen.sv
module gsp_idle_gen #(
    parameter int unsigned N_PORTS  = gsp_pkg::GSP_PORTS,
    parameter int unsigned IDLE_RUN = gsp_pkg::GSP_IDLE_RUN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PORTS-1:0] req,
    output logic               idle_pulse
);
    localparam int unsigned RW = (IDLE_RUN > 1) ? $clog2(IDLE_RUN) : 1;

    typedef struct packed {
        logic [RW-1:0] run;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        idle_pulse = 1'b0;
        if (|req) begin
            st_d.run = '0;
        end else if (st_q.run == RW'(IDLE_RUN - 1)) begin
            idle_pulse = 1'b1;
            st_d.run   = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |-> (req == '0));

    // R3
    pulse_prev_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.run != '0) |-> ($past(req) == '0));
endmodule

// File: rtl/gsp_history.sv
module gsp_history #(
    parameter int unsigned N_PORTS  = gsp_pkg::GSP_PORTS,
    parameter int unsigned HIST_LEN = gsp_pkg::GSP_HIST
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_PORTS-1:0]         req,
    input  logic [N_PORTS-1:0]         gnt,
    input  logic [$clog2(N_PORTS)-1:0] self_idx,
    input  logic                       fill_bit,
    input  logic                       idle_pulse,
    output logic [HIST_LEN-1:0]        hist
);
    localparam int unsigned SW = $clog2(N_PORTS);

    typedef struct packed {
        logic [HIST_LEN-1:0] bits;
    } hist_st_t;

    hist_st_t st_d, st_q;
    logic     own_req, own_gnt, shift_en, new_bit;

    always_comb begin
        own_req = 1'b0;
        own_gnt = 1'b0;
        for (int i = 0; i < int'(N_PORTS); i++) begin
            if (self_idx == SW'(i)) begin
                own_req = req[i];
                own_gnt = gnt[i];
            end
        end
        shift_en = (|gnt) | idle_pulse;
        new_bit  = own_req ? own_gnt : fill_bit;
        st_d     = st_q;
        if (shift_en) st_d.bits = {st_q.bits[HIST_LEN-2:0], new_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hist = st_q.bits;

    // R2
    hold_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|gnt) && !idle_pulse) |=> $stable(hist));

    // R4
    own_grant_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && own_req) |=> (hist[0] == $past(own_gnt)));

    // R5
    fill_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !own_req) |=> (hist[0] == $past(fill_bit)));
endmodule

// File: rtl/gsp_share_count.sv
module gsp_share_count #(
    parameter int unsigned HIST_LEN = gsp_pkg::GSP_HIST,
    parameter int unsigned PRIO_W   = gsp_pkg::GSP_PRIO_W
) (
    input  logic [HIST_LEN-1:0]           hist,
    input  logic [$clog2(HIST_LEN+1)-1:0] win_len,
    output logic [PRIO_W-1:0]             level
);
    localparam int unsigned LW   = $clog2(HIST_LEN + 1);
    localparam int unsigned MAXL = (1 << PRIO_W) - 1;

    logic [HIST_LEN-1:0] win_mask;
    logic [HIST_LEN-1:0] masked;
    logic [LW-1:0]       ones;

    for (genvar i = 0; i < int'(HIST_LEN); i++) begin : g_mask
        assign win_mask[i] = (win_len > LW'(i));
    end

    assign masked = hist & win_mask;

    always_comb begin
        ones = '0;
        for (int i = 0; i < int'(HIST_LEN); i++) begin
            ones = ones + LW'(masked[i]);
        end
        if (ones > LW'(MAXL)) level = PRIO_W'(MAXL);
        else                  level = ones[PRIO_W-1:0];
    end
endmodule

// File: rtl/grant_share_prio.sv
module grant_share_prio #(
    parameter int unsigned N_PORTS  = gsp_pkg::GSP_PORTS,
    parameter int unsigned HIST_LEN = gsp_pkg::GSP_HIST,
    parameter int unsigned IDLE_RUN = gsp_pkg::GSP_IDLE_RUN,
    parameter int unsigned PRIO_W   = gsp_pkg::GSP_PRIO_W
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [N_PORTS-1:0]                  req,
    input  logic [N_PORTS-1:0]                  gnt,
    input  logic [$clog2(N_PORTS)-1:0]          self_idx,
    input  logic                                fill_bit,
    input  logic [$clog2(HIST_LEN+1)-1:0]       win_len,
    input  logic [PRIO_W*(1<<PRIO_W)-1:0]       tbl_main,
    input  logic [PRIO_W*(1<<PRIO_W)-1:0]       tbl_alt,
    input  logic                                use_alt,
    output logic [PRIO_W-1:0]                   prio
);
    localparam int unsigned TW = PRIO_W * (1 << PRIO_W);

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
    } out_st_t;

    out_st_t             st_d, st_q;
    logic                idle_pulse;
    logic [HIST_LEN-1:0] hist;
    logic [PRIO_W-1:0]   level;
    logic [TW-1:0]       tbl_sel;

    gsp_idle_gen #(.N_PORTS(N_PORTS), .IDLE_RUN(IDLE_RUN)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .idle_pulse (idle_pulse)
    );

    gsp_history #(.N_PORTS(N_PORTS), .HIST_LEN(HIST_LEN)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .gnt        (gnt),
        .self_idx   (self_idx),
        .fill_bit   (fill_bit),
        .idle_pulse (idle_pulse),
        .hist       (hist)
    );

    gsp_share_count #(.HIST_LEN(HIST_LEN), .PRIO_W(PRIO_W)) u_count (
        .hist    (hist),
        .win_len (win_len),
        .level   (level)
    );

    always_comb begin
        tbl_sel   = use_alt ? tbl_alt : tbl_main;
        st_d.prio = tbl_sel[int'(level)*PRIO_W +: PRIO_W];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign prio = st_q.prio;

    // R6
    empty_window_chk: assert property (@(posedge clk) disable iff (rst)
        (win_len == '0) |-> (level == '0));
endmodule

// File: tb/test_grant_share_prio.sv
`timescale 1ns/1ps
module test_grant_share_prio;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  req, gnt;
    logic [2:0]  self_idx;
    logic        fill_bit;
    logic [5:0]  win_len;
    logic [63:0] tbl_main, tbl_alt;
    logic        use_alt;
    logic [3:0]  prio;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    grant_share_prio i_grant_share_prio (
        .clk(clk), .rst(rst), .req(req), .gnt(gnt), .self_idx(self_idx),
        .fill_bit(fill_bit), .win_len(win_len), .tbl_main(tbl_main),
        .tbl_alt(tbl_alt), .use_alt(use_alt), .prio(prio)
    );

    // stimulus per vector: {req[4:0], gnt[4:0], fill, expected prio[3:0]}
    // self_idx = 2, window = 4, identity main table so prio equals the count
    localparam logic [14:0] VEC [0:11] = '{
        {5'b00100, 5'b00100, 1'b0, 4'd1},  // R4 own grant -> 1
        {5'b00100, 5'b00010, 1'b0, 4'd1},  // R4 other grant -> 0
        {5'b00110, 5'b00100, 1'b0, 4'd2},  // R4
        {5'b00001, 5'b00001, 1'b1, 4'd3},  // R5 fill 1
        {5'b00001, 5'b00001, 1'b0, 4'd2},  // R5 fill 0, R6 oldest drops out
        {5'b00100, 5'b00000, 1'b0, 4'd2},  // R2 request without grant: no shift
        {5'b00100, 5'b00100, 1'b0, 4'd3},
        {5'b00100, 5'b00100, 1'b0, 4'd3},
        {5'b00100, 5'b00100, 1'b0, 4'd3},
        {5'b00100, 5'b00100, 1'b0, 4'd4},
        {5'b00000, 5'b00000, 1'b0, 4'd4},  // R2 single idle cycle: no shift
        {5'b10000, 5'b10000, 1'b1, 4'd4}   // R5
    };

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: prio=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #(5ns * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: expired, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = '0; gnt = '0; self_idx = 3'd2; fill_bit = 1'b0;
        win_len = 6'd4; use_alt = 1'b0;
        for (int k = 0; k < 16; k++) begin
            tbl_main[k*4 +: 4] = 4'(k);
            tbl_alt[k*4 +: 4]  = 4'(15 - k);
        end
        cyc(3);
        rst = 1'b0;
        check("R1 reset", prio, 4'd0);

        // R3 idle pulses shift in fill=1 every fourth quiet cycle
        fill_bit = 1'b1; win_len = 6'd63;
        cyc(4);  check("R3 before first pulse visible", prio, 4'd0);
        cyc(1);  check("R3 first pulse", prio, 4'd1);
        cyc(3);  check("R3 no extra pulse", prio, 4'd1);
        cyc(1);  check("R3 second pulse", prio, 4'd2);
        req = 5'b00001;
        cyc(1);
        req = 5'b00000;
        cyc(3);  check("R3 request restarts run", prio, 4'd2);
        cyc(2);  check("R3 pulse after restart", prio, 4'd3);

        rst = 1'b1;
        cyc(2);
        rst = 1'b0; fill_bit = 1'b0; win_len = 6'd4; req = 5'b11111; gnt = '0;
        cyc(1);

        for (int v = 0; v < 12; v++) begin
            req = VEC[v][14:10]; gnt = VEC[v][9:5]; fill_bit = VEC[v][4];
            cyc(1);
            req = 5'b11111; gnt = '0;
            cyc(1);
            check($sformatf("R4/R5/R2 vector %0d", v), prio, VEC[v][3:0]);
        end

        // history now holds 8 ones within the newest 10 bits
        win_len = 6'd10;
        #1 check("R9 output not yet updated", prio, 4'd4);
        cyc(1);  check("R6 window 10", prio, 4'd8);
        win_len = 6'd0;
        cyc(1);  check("R6 window 0", prio, 4'd0);
        win_len = 6'd63;
        cyc(1);  check("R6 window 63", prio, 4'd8);
        use_alt = 1'b1;
        cyc(1);  check("R8 alternate table", prio, 4'd7);
        use_alt = 1'b0;
        tbl_main[35:32] = 4'hA;
        cyc(1);  check("R8 entry 8 position", prio, 4'hA);
        tbl_main[35:32] = 4'd8;

        req = 5'b00100; gnt = 5'b00100;
        cyc(10);
        req = 5'b11111; gnt = '0;
        cyc(1);  check("R7 clamp at 15", prio, 4'd15);
        use_alt = 1'b1;
        cyc(1);  check("R8 alternate at 15", prio, 4'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule